// File: doc/BRIEF.md
# EEPROM Byte and Burst Access Engine

This block gives a host access to an external byte-wide EEPROM through four small registers: an address register, a data register, a base register and a control register. Setting a request bit in the control register starts a single-byte read or write. The bit stays set while the transfer runs, and hardware clears it when the EEPROM acknowledges. When the read bit reads back as zero, the data register holds the fetched byte.

A third control bit starts a burst. In a burst the engine walks the EEPROM byte by byte and reads records of three bytes each: an address high byte, an address low byte and a data byte. Each data byte goes out on a one-cycle memory write port. The 24-bit target address is the 9-bit base register on top, followed by the low 15 bits of the record address. The top bit of the record address is dropped. A burst ends on the record address 0xFFFF or after the engine reads the last EEPROM location.

The burst does not always start at location 0. It starts there only if no EEPROM access has completed since reset. Otherwise it starts at the location after the last completed access, so a host can place a single access in front of a burst to choose where the burst begins. The EEPROM side is a request/acknowledge byte port, and its latency may vary from one transfer to the next.

The control FSM has these states:
- `ST_IDLE`: no operation is running.
- `ST_RD`: single read.
- `ST_WR`: single write.
- `ST_B_HI`: burst, fetching the address high byte.
- `ST_B_LO`: burst, fetching the address low byte.
- `ST_B_DAT`: burst, fetching the data byte.
- `ST_B_PUT`: burst, issuing the memory write.

The FSM has these transitions:
- `ST_IDLE` to `ST_RD`, `ST_WR` or `ST_B_HI` on a control write, chosen by priority.
- `ST_RD` and `ST_WR` back to `ST_IDLE` on acknowledge.
- `ST_B_HI` to `ST_B_LO` on acknowledge, or to `ST_IDLE` if the byte came from the last location.
- `ST_B_LO` to `ST_B_DAT` on acknowledge, or to `ST_IDLE` on the 0xFFFF end marker or at the last location.
- `ST_B_DAT` to `ST_B_PUT` on acknowledge.
- `ST_B_PUT` to `ST_B_HI`, or to `ST_IDLE` if the data byte came from the last location.

Top module: `nvm_access_engine`

## Requirements
- R1: After reset, all control bits, the address, data and base registers, `ee_req` and `mem_we` are 0.
- R2: A host write is accepted only in `ST_IDLE`. `hw_sel` selects the target register: 0 = control, 1 = address (low EE_AW bits), 2 = data (low 8 bits), 3 = base (low 9 bits). Accepted values appear on `addr_o`, `data_o` and `base_o` from the next cycle.
- R3: Writing control bit 1 (read) raises `ee_req` with `ee_we`=0 at `addr_o`. On the acknowledging edge, `data_o` takes `ee_rdata` and `ctrl_o[1]` returns to 0.
- R4: Writing control bit 0 (write) raises `ee_req` with `ee_we`=1, `ee_wdata`=`data_o` and the address from `addr_o`. `ctrl_o[0]` returns to 0 on the acknowledging edge.
- R5: Only one operation runs at a time. If a control write sets several bits, read wins over write, and write wins over burst (control bit 2). The bits that lose are dropped.
- R6: While any control bit is set, host writes to every register are ignored.
- R7: Once `ee_req` is raised, `ee_addr`, `ee_we` and `ee_req` hold until the cycle in which `ee_ack` is seen.
- R8: A burst starts at EEPROM location 0 if no access has completed since reset. Otherwise it starts at the location after the last completed access, modulo 2^EE_AW.
- R9: A burst reads records of address-high, address-low and data bytes. For each record it pulses `mem_we` for one cycle with `mem_addr` = {base, record[14:0]} and `mem_wdata` = the data byte. Record bit 15 is ignored.
- R10: A burst ends, and `ctrl_o[2]` returns to 0, when a record address is 0xFFFF (no data byte is fetched for it) or after the access to location 2^EE_AW-1.
- R11: Every completed access, single or burst, updates the last-accessed location that later bursts resume from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_en | input | 1 | Host register write strobe |
| hw_sel | input | 2 | Register select (0 control, 1 address, 2 data, 3 base) |
| hw_wdata | input | HW_W | Host write value |
| ctrl_o | output | 3 | Control bits: 0 write, 1 read, 2 burst (1 = running) |
| addr_o | output | EE_AW | Address register |
| data_o | output | 8 | Data register |
| base_o | output | BASE_W | Base register (target address bits 23:15) |
| ee_req | output | 1 | EEPROM transfer request |
| ee_we | output | 1 | EEPROM transfer is a write |
| ee_addr | output | EE_AW | EEPROM location |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_ack | input | 1 | EEPROM transfer completion, one cycle |
| ee_rdata | input | 8 | EEPROM read byte, valid with ee_ack |
| mem_we | output | 1 | On-chip memory write strobe |
| mem_addr | output | MEM_AW | On-chip memory write address |
| mem_wdata | output | 8 | On-chip memory write byte |

## Verification
The hardest cases to reach are the burst ending at the top EEPROM location and the following burst wrapping around to location 0. Both depend on the hidden last-accessed location, and the ports can only steer that location through single accesses. The bench therefore places a single read at the location just before a prepared record area near the top. It then runs a burst whose records fill the area up to the last location, and runs a second burst that must start at 0. To make the top reachable in a short run, the EEPROM is shrunk to 256 locations. Randomised EEPROM latency and a request placed while the engine is busy exercise the request-hold and ignore rules.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD    = 3'd1,
        ST_WR    = 3'd2,
        ST_B_HI  = 3'd3,
        ST_B_LO  = 3'd4,
        ST_B_DAT = 3'd5,
        ST_B_PUT = 3'd6
    } nvm_state_e;

    localparam int CTL_W         = 3;
    localparam int CTL_WR_BIT    = 0;
    localparam int CTL_RD_BIT    = 1;
    localparam int CTL_BURST_BIT = 2;

    localparam logic [1:0] SEL_CTL  = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_BASE = 2'd3;
endpackage

// File: rtl/nvm_host_regs.sv
module nvm_host_regs
    import nvm_pkg::*;
#(
    parameter int HW_W   = 32,
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int BASE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [1:0]        hw_sel,
    input  logic [HW_W-1:0]   hw_wdata,
    input  logic              rd_done,
    input  logic [DW-1:0]     rd_byte,
    output logic [EE_AW-1:0]  addr_q,
    output logic [DW-1:0]     data_q,
    output logic [BASE_W-1:0] base_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            base_q <= '0;
        end else begin
            if (wr_ok && hw_sel == SEL_ADDR) begin
                addr_q <= hw_wdata[EE_AW-1:0];
            end
            if (wr_ok && hw_sel == SEL_DATA) begin
                data_q <= hw_wdata[DW-1:0];
            end else if (rd_done) begin
                data_q <= rd_byte;
            end
            if (wr_ok && hw_sel == SEL_BASE) begin
                base_q <= hw_wdata[BASE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/nvm_addr_track.sv
module nvm_addr_track #(
    parameter int EE_AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [EE_AW-1:0] done_addr,
    output logic [EE_AW-1:0] next_addr,
    output logic             last_is_max
);
    logic             seen_q;
    logic [EE_AW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (done) begin
            seen_q <= 1'b1;
            last_q <= done_addr;
        end
    end

    // Resume point: location 0 until the first access, then one past the last.
    assign next_addr   = seen_q ? (last_q + 1'b1) : '0;
    assign last_is_max = seen_q && (&last_q);
endmodule

// File: rtl/nvm_record_form.sv
module nvm_record_form #(
    parameter int DW     = 8,
    parameter int BASE_W = 9,
    parameter int MEM_AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hi,
    input  logic              cap_lo,
    input  logic              cap_dat,
    input  logic [DW-1:0]     byte_in,
    input  logic [BASE_W-1:0] base_in,
    output logic              rec_term,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    localparam int LOW_W = MEM_AW - BASE_W;

    logic [DW-1:0] hi_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] dat_q;
    logic [2*DW-1:0] rec_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            dat_q <= '0;
        end else begin
            if (cap_hi)  hi_q  <= byte_in;
            if (cap_lo)  lo_q  <= byte_in;
            if (cap_dat) dat_q <= byte_in;
        end
    end

    assign rec_word  = {hi_q, lo_q};
    // End marker is judged on the stored high byte and the arriving low byte.
    assign rec_term  = &{hi_q, byte_in};
    assign mem_addr  = {base_in, rec_word[LOW_W-1:0]};
    assign mem_wdata = dat_q;
endmodule

// File: rtl/nvm_access_engine.sv
module nvm_access_engine
    import nvm_pkg::*;
#(
    parameter int HW_W   = 32,
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int BASE_W = 9,
    parameter int MEM_AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic [1:0]        hw_sel,
    input  logic [HW_W-1:0]   hw_wdata,
    output logic [CTL_W-1:0]  ctrl_o,
    output logic [EE_AW-1:0]  addr_o,
    output logic [DW-1:0]     data_o,
    output logic [BASE_W-1:0] base_o,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [DW-1:0]     ee_wdata,
    input  logic              ee_ack,
    input  logic [DW-1:0]     ee_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    nvm_state_e st_q, st_d;

    logic             idle, host_ok, ctl_go, xfer_done, at_last;
    logic             rd_done, cap_hi, cap_lo, cap_dat;
    logic             rec_term, last_is_max;
    logic [EE_AW-1:0] trk_next;

    assign idle      = (st_q == ST_IDLE);
    assign host_ok   = hw_en && idle;
    assign ctl_go    = host_ok && (hw_sel == SEL_CTL);
    assign xfer_done = ee_req && ee_ack;
    assign at_last   = &ee_addr;

    nvm_host_regs #(.HW_W(HW_W), .EE_AW(EE_AW), .DW(DW), .BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(host_ok), .hw_sel(hw_sel), .hw_wdata(hw_wdata),
        .rd_done(rd_done), .rd_byte(ee_rdata),
        .addr_q(addr_o), .data_q(data_o), .base_q(base_o)
    );

    nvm_addr_track #(.EE_AW(EE_AW)) u_trk (
        .clk(clk), .rst_n(rst_n), .done(xfer_done), .done_addr(ee_addr),
        .next_addr(trk_next), .last_is_max(last_is_max)
    );

    nvm_record_form #(.DW(DW), .BASE_W(BASE_W), .MEM_AW(MEM_AW)) u_rec (
        .clk(clk), .rst_n(rst_n), .cap_hi(cap_hi), .cap_lo(cap_lo), .cap_dat(cap_dat),
        .byte_in(ee_rdata), .base_in(base_o), .rec_term(rec_term),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ctl_go) begin
                    if (hw_wdata[CTL_RD_BIT])         st_d = ST_RD;
                    else if (hw_wdata[CTL_WR_BIT])    st_d = ST_WR;
                    else if (hw_wdata[CTL_BURST_BIT]) st_d = ST_B_HI;
                end
            end
            ST_RD, ST_WR: begin
                if (ee_ack) st_d = ST_IDLE;
            end
            ST_B_HI: begin
                if (ee_ack) st_d = at_last ? ST_IDLE : ST_B_LO;
            end
            ST_B_LO: begin
                if (ee_ack) st_d = (rec_term || at_last) ? ST_IDLE : ST_B_DAT;
            end
            ST_B_DAT: begin
                if (ee_ack) st_d = ST_B_PUT;
            end
            ST_B_PUT: begin
                st_d = last_is_max ? ST_IDLE : ST_B_HI;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        ee_req  = 1'b0;
        ee_we   = 1'b0;
        ee_addr = trk_next;
        mem_we  = 1'b0;
        ctrl_o  = '0;
        rd_done = 1'b0;
        cap_hi  = 1'b0;
        cap_lo  = 1'b0;
        cap_dat = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_RD: begin
                ee_req             = 1'b1;
                ee_addr            = addr_o;
                ctrl_o[CTL_RD_BIT] = 1'b1;
                rd_done            = ee_ack;
            end
            ST_WR: begin
                ee_req             = 1'b1;
                ee_we              = 1'b1;
                ee_addr            = addr_o;
                ctrl_o[CTL_WR_BIT] = 1'b1;
            end
            ST_B_HI: begin
                ee_req                = 1'b1;
                ctrl_o[CTL_BURST_BIT] = 1'b1;
                cap_hi                = ee_ack;
            end
            ST_B_LO: begin
                ee_req                = 1'b1;
                ctrl_o[CTL_BURST_BIT] = 1'b1;
                cap_lo                = ee_ack;
            end
            ST_B_DAT: begin
                ee_req                = 1'b1;
                ctrl_o[CTL_BURST_BIT] = 1'b1;
                cap_dat               = ee_ack;
            end
            ST_B_PUT: begin
                mem_we                = 1'b1;
                ctrl_o[CTL_BURST_BIT] = 1'b1;
            end
            default: ;
        endcase
    end

    assign ee_wdata = data_o;
endmodule

// File: rtl/nvm_engine_chk.sv
module nvm_engine_chk #(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9,
    parameter int MEM_AW = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        ctrl_o,
    input logic [EE_AW-1:0]  addr_o,
    input logic [BASE_W-1:0] base_o,
    input logic              ee_req,
    input logic              ee_we,
    input logic [EE_AW-1:0]  ee_addr,
    input logic              ee_ack,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr
);
    p_single_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_o));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we)));

    p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_o[1]) |-> $past(ee_ack));

    p_wr_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && ee_we) |-> ctrl_o[0]);

    p_store_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ctrl_o[2] && mem_addr[MEM_AW-1 -: BASE_W] == base_o));

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o != 3'b000) |=> ($stable(addr_o) && $stable(base_o)));
endmodule

bind nvm_access_engine nvm_engine_chk #(.EE_AW(EE_AW), .BASE_W(BASE_W), .MEM_AW(MEM_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_o(ctrl_o), .addr_o(addr_o), .base_o(base_o),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_ack(ee_ack),
    .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/sim_nvm_access_engine.sv
`timescale 1ns/1ps
module sim_nvm_access_engine;
    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b0;
    logic [1:0]  hw_sel = 2'd0;
    logic [31:0] hw_wdata = 32'd0;
    logic [2:0]  ctrl_o;
    logic [AW-1:0] addr_o;
    logic [7:0]  data_o;
    logic [8:0]  base_o;
    logic        ee_req, ee_we;
    logic [AW-1:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = 8'd0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    always #4 clk = ~clk;

    nvm_access_engine #(.EE_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_wdata(hw_wdata),
        .ctrl_o(ctrl_o), .addr_o(addr_o), .data_o(data_o), .base_o(base_o),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // EEPROM model with random latency
    logic [7:0]    ee_mem [256];
    logic          m_busy = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic          m_we = 1'b0;
    logic [7:0]    m_wd = 8'd0;
    int            m_cnt = 0;
    int            hold_err = 0;

    always @(posedge clk) begin
        if (ee_ack) begin
            ee_ack <= 1'b0;
            m_busy <= 1'b0;
        end else if (!m_busy && ee_req) begin
            m_busy <= 1'b1;
            m_addr <= ee_addr;
            m_we   <= ee_we;
            m_wd   <= ee_wdata;
            m_cnt  <= int'($urandom_range(0, 3));
        end else if (m_busy) begin
            if (!ee_req || ee_addr != m_addr || ee_we != m_we) hold_err <= hold_err + 1;
            if (m_cnt == 0) begin
                ee_ack   <= 1'b1;
                ee_rdata <= ee_mem[m_addr];
                if (m_we) ee_mem[m_addr] <= m_wd;
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end
    end

    // Memory write log
    logic [23:0] log_addr [128];
    logic [7:0]  log_dat  [128];
    int          log_n = 0;

    always @(negedge clk) begin
        if (mem_we && log_n < 128) begin
            log_addr[log_n] = mem_addr;
            log_dat[log_n]  = mem_wdata;
            log_n++;
        end
    end

    // Bench-side expectation
    bit          exp_seen = 1'b0;
    logic [7:0]  exp_last = 8'd0;
    logic [23:0] exp_addr [128];
    logic [7:0]  exp_dat  [128];
    int          exp_n = 0;

    task automatic predict_burst(input logic [8:0] base);
        logic [7:0]  pos;
        logic [7:0]  hi, lo;
        logic [15:0] rec;
        bit          fin;
        pos   = exp_seen ? exp_last + 8'd1 : 8'd0;
        exp_n = 0;
        fin   = 1'b0;
        while (!fin) begin
            hi = ee_mem[pos];
            exp_last = pos;
            if (pos == 8'hFF) begin fin = 1'b1; end
            else begin
                pos = pos + 8'd1;
                lo = ee_mem[pos];
                exp_last = pos;
                rec = {hi, lo};
                if (rec == 16'hFFFF || pos == 8'hFF) begin fin = 1'b1; end
                else begin
                    pos = pos + 8'd1;
                    exp_last = pos;
                    exp_addr[exp_n] = {base, rec[14:0]};
                    exp_dat[exp_n]  = ee_mem[pos];
                    exp_n++;
                    if (pos == 8'hFF) fin = 1'b1;
                    else pos = pos + 8'd1;
                end
            end
        end
        exp_seen = 1'b1;
    endtask

    task automatic host_wr(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        hw_en = 1'b1; hw_sel = sel; hw_wdata = v;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (ctrl_o != 3'b000 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(ctrl_o == 3'b000, req, "control bits clear", {29'd0, ctrl_o}, 32'd0);
    endtask

    task automatic run_burst(input logic [8:0] base, input string tag);
        host_wr(2'd3, {23'd0, base});
        predict_burst(base);
        log_n = 0;
        host_wr(2'd0, 32'h4);
        wait_idle("R10");
        @(negedge clk);
        chk(log_n == exp_n, "R10", {tag, " record count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_addr[i] == exp_addr[i], "R9", {tag, " target address"}, {8'd0, log_addr[i]}, {8'd0, exp_addr[i]});
            chk(log_dat[i] == exp_dat[i], "R9", {tag, " target data"}, {24'd0, log_dat[i]}, {24'd0, exp_dat[i]});
        end
    endtask

    task automatic single_rd(input logic [7:0] a, input string req);
        host_wr(2'd1, {24'd0, a});
        host_wr(2'd0, 32'h2);
        wait_idle(req);
        chk(data_o == ee_mem[a], req, "read byte", {24'd0, data_o}, {24'd0, ee_mem[a]});
        exp_seen = 1'b1; exp_last = a;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] a, d, keep;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 256; i++) ee_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ctrl_o == 3'b000 && ee_req == 1'b0 && mem_we == 1'b0, "R1", "idle outputs", {27'd0, ctrl_o, ee_req, mem_we}, 32'd0);
        chk(addr_o == 8'd0 && data_o == 8'd0 && base_o == 9'd0, "R1", "registers zero", {7'd0, base_o, data_o, addr_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8/R9: first burst from location 0, record MSB dropped
        ee_mem[0] = 8'h80; ee_mem[1] = 8'h12; ee_mem[2] = 8'hA5;
        ee_mem[3] = 8'h7F; ee_mem[4] = 8'hFF; ee_mem[5] = 8'h3C;
        run_burst(9'h1A5, "R8 burst from zero");
        chk(log_addr[0] == 24'hD28012, "R9", "MSB ignored", {8'd0, log_addr[0]}, 32'hD28012);
        chk(base_o == 9'h1A5, "R2", "base register", {23'd0, base_o}, 32'h1A5);

        // R10/R11: stop on end marker, next burst resumes after it
        ee_mem[8] = 8'h00; ee_mem[9] = 8'h05; ee_mem[10] = 8'h77;
        run_burst(9'h1A5, "R11 resume after marker");
        chk(log_addr[0] == 24'hD28005, "R11", "resumed record", {8'd0, log_addr[0]}, 32'hD28005);

        // R2: register writes
        host_wr(2'd1, 32'hFFFF_FF3C);
        host_wr(2'd2, 32'h0000_01C4);
        chk(addr_o == 8'h3C && data_o == 8'hC4, "R2", "addr/data registers", {16'd0, addr_o, data_o}, 32'h3CC4);

        // R3/R4: random single accesses
        for (int k = 0; k < 40; k++) begin
            a = 8'($urandom_range(16, 240));
            d = 8'($urandom);
            if ($urandom_range(0, 1) == 1) begin
                host_wr(2'd1, {24'd0, a});
                host_wr(2'd2, {24'd0, d});
                host_wr(2'd0, 32'h1);
                wait_idle("R4");
                chk(ee_mem[a] == d, "R4", "written byte", {24'd0, ee_mem[a]}, {24'd0, d});
                exp_seen = 1'b1; exp_last = a;
            end else begin
                ee_mem[a] = d;
                single_rd(a, "R3");
            end
        end

        // R5: read beats write, write beats burst
        ee_mem[20] = 8'h11;
        host_wr(2'd1, 32'd20);
        host_wr(2'd2, 32'h99);
        host_wr(2'd0, 32'h3);
        wait_idle("R5");
        chk(data_o == 8'h11 && ee_mem[20] == 8'h11, "R5", "read wins", {16'd0, data_o, ee_mem[20]}, 32'h1111);
        host_wr(2'd2, 32'h99);
        log_n = 0;
        host_wr(2'd0, 32'h5);
        wait_idle("R5");
        @(negedge clk);
        chk(ee_mem[20] == 8'h99 && log_n == 0, "R5", "write wins over burst", {16'd0, ee_mem[20], 8'(log_n)}, 32'h9900);
        exp_seen = 1'b1; exp_last = 8'd20;

        // R6: writes ignored while busy
        host_wr(2'd1, 32'd30);
        host_wr(2'd0, 32'h2);
        host_wr(2'd1, 32'd31);
        wait_idle("R6");
        chk(addr_o == 8'd30, "R6", "address kept while busy", {24'd0, addr_o}, 32'd30);
        keep = ee_mem[30];
        log_n = 0;
        host_wr(2'd0, 32'h2);
        host_wr(2'd0, 32'h4);
        wait_idle("R6");
        repeat (4) @(negedge clk);
        chk(log_n == 0 && ctrl_o == 3'b000 && data_o == keep, "R6", "burst request ignored while busy",
            {16'd0, 8'(log_n), 5'd0, ctrl_o}, 32'd0);
        exp_seen = 1'b1; exp_last = 8'd30;

        // R10/R11: burst ending at the top location, then wrap to zero
        ee_mem[250] = 8'h01; ee_mem[251] = 8'h10; ee_mem[252] = 8'h99;
        ee_mem[253] = 8'h82; ee_mem[254] = 8'h20; ee_mem[255] = 8'h44;
        single_rd(8'd249, "R11");
        run_burst(9'h003, "R10 top location");
        chk(log_n == 2, "R10", "stops after last location", log_n, 32'd2);
        ee_mem[0] = 8'hFF; ee_mem[1] = 8'hFF;
        run_burst(9'h003, "R8 wrap to zero");

        // Random bursts over random contents
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 256; i++) ee_mem[i] = 8'($urandom);
            single_rd(8'($urandom_range(0, 200)), "R11");
            run_burst(9'($urandom), "R9 random burst");
        end

        // R7: request held steady until acknowledge
        chk(hold_err == 0, "R7", "request stability", hold_err, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule